// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the slave-side command decoder of a serial NOR flash. The serial pins are sampled by the chip's system clock. While chip select is low, the block deserialises the mode-0 bit stream. The first byte of a frame is the opcode. For addressed commands the next three bytes are a 24-bit byte address, and any later bytes are data. The rising edge of chip select closes the frame. At that point the block decides whether the command reaches the memory core.

A frame is forwarded only when all of these hold:
- it is a modifying command;
- a write-enable latch was set by an earlier frame;
- chip select rose on a byte boundary;
- the frame carried enough bytes for its opcode;
- the core is not busy;
- the protection flag does not cover the target.

An accepted command leaves as a one-cycle issue pulse carrying the opcode, the address and the byte count. The block then holds busy until the core reports done. A status-read opcode streams a status byte out on the falling serial clock edges. That byte holds the busy flag and the write-enable latch, and it repeats for as long as the frame lasts.

Top module: `spi_cmd_front`

## Requirements
- R1: The opcode is the first 8 bits sampled on rising serial clock edges (MSB first) after chip select falls. For the addressed opcodes 0x02 (program), 0x20 (small erase) and 0xD8 (large erase), the next 24 bits, MSB first, form the address carried on `issue_addr`.
- R2: An accepted command produces `issue_vld` high for exactly one clock, with `issue_op` and `issue_addr` set. `issue_nbytes` gives the count of complete bytes in the frame, opcode included, and saturates at 2^CNT_W-1.
- R3: A modifying command (0x02, 0x20, 0xD8, 0xC7 chip erase, 0x01 status write) is issued only if chip select rises after a whole number of bytes. A frame with trailing partial bits is dropped.
- R4: Minimum frame lengths apply. Program needs at least 5 bytes, the erases 0x20 and 0xD8 need 4, status write needs 2 and chip erase needs 1. A shorter frame is dropped.
- R5: Opcode 0x06 ending on a byte boundary sets a write-enable latch. A modifying command is issued only while the latch is set. Any modifying frame judged while not busy clears the latch, whether it is issued or dropped.
- R6: `busy` rises together with `issue_vld` and falls on the clock after `core_done` is sampled high. While busy, every frame has no effect, including 0x06.
- R7: If `prot_hit` is high when chip select rises, opcodes 0x02, 0x20, 0xD8 and 0xC7 are dropped. Opcode 0x01 is not affected by `prot_hit`.
- R8: For opcode 0x05, `spi_miso` presents the status byte MSB first and changes on falling serial clock edges, starting after the opcode's last bit. Bit 0 is busy, bit 1 is the write-enable latch and the other bits are 0. The byte repeats until chip select rises. Outside such a frame `spi_miso` is 0.
- R9: A status read or a write-enable frame ended mid-byte, and any unknown opcode, change neither the write-enable latch nor `busy`, and issue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (status stream) |
| prot_hit | input | 1 | Target of the current command lies in a protected region |
| core_done | input | 1 | Core finished the issued operation |
| issue_vld | output | 1 | One-cycle command issue pulse |
| issue_op | output | 8 | Opcode of the issued command |
| issue_addr | output | 24 | Address of the issued command |
| issue_nbytes | output | CNT_W | Complete bytes received in the issued frame |
| busy | output | 1 | Core operation in progress |

## Verification
The bench builds the block with CNT_W = 6 and the default three address bytes. This puts the byte-count ceiling at 63, so a 70-byte program frame can show saturation within a short run. With that ceiling the frame still ends aligned and is still issued, which separates the saturating counter from the bit position used by the alignment rule. The directed scenarios cover each drop reason on its own and the busy lockout. They also cover a status stream read twice in one frame.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_WSTAT  = 8'h01;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_RSTAT  = 8'h05;
  localparam logic [7:0] OP_WENA   = 8'h06;
  localparam logic [7:0] OP_ERS_SM = 8'h20;
  localparam logic [7:0] OP_ERS_CH = 8'hC7;
  localparam logic [7:0] OP_ERS_LG = 8'hD8;

  function automatic logic is_modify(input logic [7:0] op);
    return (op == OP_WSTAT) || (op == OP_PROG) || (op == OP_ERS_SM) ||
           (op == OP_ERS_CH) || (op == OP_ERS_LG);
  endfunction

  // Opcodes whose target region is subject to the protection flag
  function automatic logic is_guarded(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERS_SM) ||
           (op == OP_ERS_CH) || (op == OP_ERS_LG);
  endfunction

  function automatic logic [3:0] min_bytes(input logic [7:0] op);
    case (op)
      OP_PROG:              return 4'd5;
      OP_ERS_SM, OP_ERS_LG: return 4'd4;
      OP_WSTAT:             return 4'd2;
      default:              return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csn,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_act,
  output logic frame_start,
  output logic frame_end,
  output logic mosi_s
);

  logic sclk_r, sclk_rr, csn_r, csn_rr, mosi_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r  <= 1'b0;
      sclk_rr <= 1'b0;
      csn_r   <= 1'b1;
      csn_rr  <= 1'b1;
      mosi_r  <= 1'b0;
    end else begin
      sclk_r  <= sclk;
      sclk_rr <= sclk_r;
      csn_r   <= csn;
      csn_rr  <= csn_r;
      mosi_r  <= mosi;
    end
  end

  assign frame_act   = ~csn_r;
  assign frame_start = ~csn_r & csn_rr;
  assign frame_end   = csn_r & ~csn_rr;
  assign sclk_rise   = sclk_r & ~sclk_rr & ~csn_r;
  assign sclk_fall   = ~sclk_r & sclk_rr & ~csn_r;
  assign mosi_s      = mosi_r;

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
  parameter int CNT_W      = 16,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    sclk_rise,
  input  logic                    mosi_s,
  output logic [7:0]              op,
  output logic                    op_vld,
  output logic [8*ADDR_BYTES-1:0] addr,
  output logic [2:0]              bitpos,
  output logic [CNT_W-1:0]        nbytes
);

  localparam int AW = 8 * ADDR_BYTES;
  localparam logic [CNT_W-1:0] BYTES_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [6:0]       sh_q, sh_d;
  logic [7:0]       op_q, op_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [2:0]       pos_q, pos_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d   = sh_q;
    op_d   = op_q;
    addr_d = addr_q;
    pos_d  = pos_q;
    cnt_d  = cnt_q;
    if (frame_start) begin
      pos_d  = 3'd0;
      cnt_d  = '0;
      addr_d = '0;
    end else if (sclk_rise) begin
      sh_d  = {sh_q[5:0], mosi_s};
      pos_d = pos_q + 3'd1;
      if (pos_q == 3'd7 && cnt_q != BYTES_MAX) cnt_d = cnt_q + ONE;
      if (pos_q == 3'd7 && cnt_q == '0) op_d = {sh_q, mosi_s};
      if (cnt_q != '0 && cnt_q <= ADDR_LAST) addr_d = {addr_q[AW-2:0], mosi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      op_q   <= '0;
      addr_q <= '0;
      pos_q  <= 3'd0;
      cnt_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      pos_q  <= pos_d;
      cnt_q  <= cnt_d;
    end
  end

  assign op     = op_q;
  assign op_vld = (cnt_q != '0);
  assign addr   = addr_q;
  assign bitpos = pos_q;
  assign nbytes = cnt_q;

endmodule

// File: rtl/spi_cmd_gate.sv
module spi_cmd_gate
  import spi_cmd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [7:0]       op,
  input  logic             op_vld,
  input  logic [AW-1:0]    addr,
  input  logic [2:0]       bitpos,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             prot_hit,
  input  logic             core_done,
  output logic             issue_vld,
  output logic [7:0]       issue_op,
  output logic [AW-1:0]    issue_addr,
  output logic [CNT_W-1:0] issue_nbytes,
  output logic             busy,
  output logic             wel
);

  logic judge, aligned, accept;
  logic busy_q, busy_d, wel_q, wel_d, vld_q;
  logic [7:0]       op_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    judge   = frame_end && op_vld && !busy_q;
    aligned = (bitpos == 3'd0);
    accept  = judge && is_modify(op) && wel_q && aligned &&
              (nbytes >= CNT_W'(min_bytes(op))) &&
              !(prot_hit && is_guarded(op));
    wel_d = wel_q;
    if (judge) begin
      if (op == OP_WENA && aligned) wel_d = 1'b1;
      else if (is_modify(op))       wel_d = 1'b0;
    end
    busy_d = busy_q;
    if (accept)                 busy_d = 1'b1;
    else if (busy_q && core_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      vld_q  <= 1'b0;
      op_q   <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      wel_q  <= wel_d;
      vld_q  <= accept;
      if (accept) begin
        op_q   <= op;
        addr_q <= addr;
        cnt_q  <= nbytes;
      end
    end
  end

  assign issue_vld    = vld_q;
  assign issue_op     = op_q;
  assign issue_addr   = addr_q;
  assign issue_nbytes = cnt_q;
  assign busy         = busy_q;
  assign wel          = wel_q;

endmodule

// File: rtl/spi_stat_tx.sv
module spi_stat_tx
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_act,
  input  logic       sclk_fall,
  input  logic [7:0] op,
  input  logic       op_vld,
  input  logic [2:0] bitpos,
  input  logic       busy,
  input  logic       wel,
  output logic       miso
);

  logic [7:0] status;
  logic       miso_q, miso_d;

  always_comb begin
    status = {6'b0, wel, busy};
    miso_d = miso_q;
    if (!frame_act)
      miso_d = 1'b0;
    else if (sclk_fall)
      miso_d = (op_vld && op == OP_RSTAT) ? status[3'd7 - bitpos] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miso_q <= 1'b0;
    else        miso_q <= miso_d;
  end

  assign miso = miso_q;

endmodule

// File: rtl/spi_cmd_front.sv
module spi_cmd_front #(
  parameter int CNT_W      = 16,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_csn,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  input  logic                    prot_hit,
  input  logic                    core_done,
  output logic                    issue_vld,
  output logic [7:0]              issue_op,
  output logic [8*ADDR_BYTES-1:0] issue_addr,
  output logic [CNT_W-1:0]        issue_nbytes,
  output logic                    busy
);

  localparam int AW = 8 * ADDR_BYTES;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic sclk_rise, sclk_fall, frame_act, frame_start, frame_end, mosi_s;
  logic [7:0]       op;
  logic             op_vld, wel;
  logic [AW-1:0]    addr;
  logic [2:0]       bitpos;
  logic [CNT_W-1:0] nbytes;

  spi_in_sync u_sync (
    .clk(clk), .rst_n(rst_sync), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .frame_act(frame_act),
    .frame_start(frame_start), .frame_end(frame_end), .mosi_s(mosi_s)
  );

  spi_frame_rx #(.CNT_W(CNT_W), .ADDR_BYTES(ADDR_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_sync), .frame_start(frame_start), .sclk_rise(sclk_rise),
    .mosi_s(mosi_s), .op(op), .op_vld(op_vld), .addr(addr), .bitpos(bitpos),
    .nbytes(nbytes)
  );

  spi_cmd_gate #(.CNT_W(CNT_W), .AW(AW)) u_gate (
    .clk(clk), .rst_n(rst_sync), .frame_end(frame_end), .op(op), .op_vld(op_vld),
    .addr(addr), .bitpos(bitpos), .nbytes(nbytes), .prot_hit(prot_hit),
    .core_done(core_done), .issue_vld(issue_vld), .issue_op(issue_op),
    .issue_addr(issue_addr), .issue_nbytes(issue_nbytes), .busy(busy), .wel(wel)
  );

  spi_stat_tx u_tx (
    .clk(clk), .rst_n(rst_sync), .frame_act(frame_act), .sclk_fall(sclk_fall),
    .op(op), .op_vld(op_vld), .bitpos(bitpos), .busy(busy), .wel(wel),
    .miso(spi_miso)
  );

endmodule

// File: rtl/spi_cmd_front_chk.sv
module spi_cmd_front_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_csn,
  input logic spi_miso,
  input logic core_done,
  input logic issue_vld,
  input logic busy
);

  // R2: issue is a single-cycle pulse
  p_issue_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> !issue_vld);

  // R6: busy is set together with the issue pulse
  p_busy_with_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> busy);

  // R6: busy holds until core_done
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_done) |=> busy);

  // R6: busy drops after core_done
  p_busy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_done) |=> !busy);

  // R3: issue only follows a chip-select rise
  p_issue_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> $past(spi_csn));

  // R8: output idle while deselected
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_csn, 2) && $past(spi_csn) && spi_csn) |-> !spi_miso);

endmodule

bind spi_cmd_front spi_cmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_miso(spi_miso),
  .core_done(core_done), .issue_vld(issue_vld), .busy(busy)
);

// File: tb/sim_spi_cmd_front.sv
module sim_spi_cmd_front;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;

  logic clk, rst_n, sclk, csn, mosi, miso, prot_hit, core_done;
  logic issue_vld, busy;
  logic [7:0]       issue_op;
  logic [23:0]      issue_addr;
  logic [CNT_W-1:0] issue_nbytes;

  int checks = 0, fails = 0;
  int n_issue = 0;
  logic [7:0]       cap_op;
  logic [23:0]      cap_addr;
  logic [CNT_W-1:0] cap_cnt;
  bit finished = 0;

  spi_cmd_front #(.CNT_W(CNT_W), .ADDR_BYTES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .prot_hit(prot_hit), .core_done(core_done),
    .issue_vld(issue_vld), .issue_op(issue_op), .issue_addr(issue_addr),
    .issue_nbytes(issue_nbytes), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && issue_vld) begin
    n_issue++;
    cap_op   = issue_op;
    cap_addr = issue_addr;
    cap_cnt  = issue_nbytes;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic o);
    mosi = b;
    wait_n(2);
    o = miso;
    sclk = 1'b1;
    wait_n(3);
    sclk = 1'b0;
    wait_n(3);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx;
    xfer(tx, rx);
  endtask

  task automatic cs_lo();
    csn = 1'b0;
    wait_n(3);
  endtask

  task automatic cs_hi();
    csn = 1'b1;
    wait_n(6);
  endtask

  task automatic wren();
    cs_lo(); send(8'h06); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    cs_lo(); send(8'h05); xfer(8'h00, s); cs_hi();
  endtask

  task automatic addr_cmd(input logic [7:0] op, input logic [23:0] a);
    send(op); send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic done_pulse();
    core_done = 1'b1;
    wait_n(1);
    core_done = 1'b0;
    wait_n(2);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk(busy == 1'b0, "R6", "busy after reset", busy, 0);
    chk(issue_vld == 1'b0, "R2", "issue after reset", issue_vld, 0);
    chk(miso == 1'b0, "R8", "miso idle", miso, 0);
    rdsr(s);
    chk(s == 8'h00, "R8", "status after reset", s, 8'h00);
  endtask

  task automatic t_wren_stream();
    logic [7:0] s1, s2;
    wren();
    cs_lo(); send(8'h05); xfer(8'h00, s1); xfer(8'h00, s2); cs_hi();
    chk(s1 == 8'h02, "R8", "status byte 1 with latch", s1, 8'h02);
    chk(s2 == 8'h02, "R8", "status byte repeats", s2, 8'h02);
    chk(miso == 1'b0, "R8", "miso idle after frame", miso, 0);
  endtask

  task automatic t_erase_ok();
    int n0 = n_issue;
    logic [7:0] s;
    cs_lo(); addr_cmd(8'h20, 24'h123456); cs_hi();
    chk(n_issue == n0 + 1, "R2", "erase issue count", n_issue - n0, 1);
    chk(cap_op == 8'h20, "R1", "erase opcode", cap_op, 8'h20);
    chk(cap_addr == 24'h123456, "R1", "erase address", cap_addr, 24'h123456);
    chk(cap_cnt == 4, "R2", "erase byte count", cap_cnt, 4);
    chk(busy == 1'b1, "R6", "busy after issue", busy, 1);
    rdsr(s);
    chk(s == 8'h01, "R5", "latch cleared, busy shown", s, 8'h01);
    done_pulse();
    chk(busy == 1'b0, "R6", "busy cleared by done", busy, 0);
  endtask

  task automatic t_no_latch();
    int n0 = n_issue;
    cs_lo(); addr_cmd(8'hD8, 24'h010000); cs_hi();
    chk(n_issue == n0, "R5", "erase without latch dropped", n_issue - n0, 0);
  endtask

  task automatic t_misaligned();
    int n0 = n_issue;
    logic o;
    logic [7:0] s;
    wren();
    cs_lo(); addr_cmd(8'h02, 24'h000100); send(8'hA5);
    bit_x(1'b1, o); bit_x(1'b0, o); bit_x(1'b1, o);
    cs_hi();
    chk(n_issue == n0, "R3", "program with trailing bits dropped", n_issue - n0, 0);
    rdsr(s);
    chk(s == 8'h00, "R5", "latch cleared by rejected program", s, 8'h00);
  endtask

  task automatic t_short();
    int n0 = n_issue;
    wren();
    cs_lo(); send(8'h20); send(8'h00); send(8'h10); cs_hi();
    chk(n_issue == n0, "R4", "3-byte erase dropped", n_issue - n0, 0);
    wren();
    cs_lo(); addr_cmd(8'h02, 24'h000200); cs_hi();
    chk(n_issue == n0, "R4", "program without data dropped", n_issue - n0, 0);
  endtask

  task automatic t_busy_lock();
    int n0 = n_issue;
    logic [7:0] s;
    wren();
    cs_lo(); send(8'hC7); cs_hi();
    chk(n_issue == n0 + 1 && cap_op == 8'hC7 && cap_cnt == 1, "R4",
        "chip erase one byte issued", cap_op, 8'hC7);
    wren();
    rdsr(s);
    chk(s == 8'h01, "R6", "write enable ignored while busy", s, 8'h01);
    cs_lo(); addr_cmd(8'h02, 24'h000300); send(8'h11); cs_hi();
    chk(n_issue == n0 + 1, "R6", "program ignored while busy", n_issue - n0, 1);
    done_pulse();
    rdsr(s);
    chk(s == 8'h00, "R6", "idle status after done", s, 8'h00);
  endtask

  task automatic t_protect();
    int n0 = n_issue;
    logic [7:0] s;
    prot_hit = 1'b1;
    wren();
    cs_lo(); addr_cmd(8'hD8, 24'h1F0000); cs_hi();
    chk(n_issue == n0, "R7", "protected erase dropped", n_issue - n0, 0);
    rdsr(s);
    chk(s == 8'h00, "R7", "latch cleared by protected erase", s, 8'h00);
    wren();
    cs_lo(); send(8'h01); send(8'h3C); cs_hi();
    chk(n_issue == n0 + 1 && cap_op == 8'h01 && cap_cnt == 2, "R7",
        "status write ignores protection", n_issue - n0, 1);
    prot_hit = 1'b0;
    done_pulse();
  endtask

  task automatic t_partial_reads();
    int n0 = n_issue;
    logic o;
    logic [7:0] s;
    cs_lo(); send(8'h05); bit_x(1'b0, o); bit_x(1'b0, o); bit_x(1'b0, o); cs_hi();
    cs_lo(); send(8'h06); bit_x(1'b1, o); cs_hi();
    cs_lo(); send(8'h9A); send(8'h00); cs_hi();
    rdsr(s);
    chk(s == 8'h00 && n_issue == n0, "R9", "partial frames have no effect", s, 8'h00);
    wren();
    rdsr(s);
    chk(s == 8'h02, "R9", "aligned write enable after partial read", s, 8'h02);
  endtask

  task automatic t_prog_count();
    int n0 = n_issue;
    cs_lo(); addr_cmd(8'h02, 24'hABCDEF);
    for (int i = 0; i < 5; i++) send(8'(i));
    cs_hi();
    chk(n_issue == n0 + 1 && cap_addr == 24'hABCDEF, "R1", "program address",
        cap_addr, 24'hABCDEF);
    chk(cap_cnt == 9, "R2", "program byte count", cap_cnt, 9);
    done_pulse();
  endtask

  task automatic t_saturate();
    int n0 = n_issue;
    wren();
    cs_lo(); addr_cmd(8'h02, 24'h000400);
    for (int i = 0; i < 66; i++) send(8'hFF);
    cs_hi();
    chk(n_issue == n0 + 1, "R2", "long program issued", n_issue - n0, 1);
    chk(cap_cnt == 63, "R2", "byte count saturates", cap_cnt, 63);
    done_pulse();
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0;
    prot_hit = 1'b0; core_done = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_wren_stream();
    t_erase_ok();
    t_no_latch();
    t_misaligned();
    t_short();
    t_busy_lock();
    t_protect();
    t_partial_reads();
    wren();
    t_prog_count();
    t_saturate();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule